// File: doc/BRIEF.md
# Sign-Split Segmented-Weight Multiply-Accumulate Unit

This block accumulates signed products of 8-bit sign-magnitude activations and weights. It never forms a signed product. The sign of each product (XNOR of the two sign bits) steers the whole operation into one of two unsigned banks: one collects positive products, the other negative ones. Inside each bank, the 7-bit weight magnitude is cut into a 3-bit upper slice and a 4-bit lower slice. Each slice feeds its own counter, which adds activation magnitude times slice value.

The four counters stay separate until a readout is requested. The readout then forms each bank total by shifting the upper counter left by four and adding the lower counter. It subtracts the negative total from the positive total and presents a two's-complement result for one clock.

Operands arrive on a valid/ready stream. A clear input empties all four counters, so a new batch can start.

Top module: `ssmac_top`

## Requirements
- R1: After reset all four counters hold zero, `res_valid` is low, and a readout returns 0.
- R2: When the sign bits (bit 7) of activation and weight are equal, the product magnitude is added to the positive bank and the result grows by that amount.
- R3: When the sign bits differ, the product magnitude is added to the negative bank and the result shrinks by that amount.
- R4: Weight bits 6:4 feed the upper counter and bits 3:0 feed the lower counter. Readout recombines them as upper×16 + lower, so the result equals the exact signed sum of activation×weight for any magnitudes 0..127.
- R5: An accepted operation whose activation magnitude or weight magnitude (bits 6:0) is zero leaves the result unchanged, whatever the sign bits are.
- R6: A cycle with `clear` high zeroes all four counters; a readout afterwards returns 0.
- R7: A cycle with `rd_req` high produces exactly one cycle of `res_valid` on the next clock. The result reflects every operation accepted before the `rd_req` cycle. Back-to-back requests give back-to-back results.
- R8: 256 operations of magnitude 127×127 into one bank do not overflow; the result is ±4129024.
- R9: `in_ready` is low while `clear` is high, and an operation offered in that cycle is not accumulated.
- R10: A readout does not disturb the counters; repeated readouts return the same running sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Zero all counters (starts a new batch) |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Operand pair can be taken |
| in_act | input | 8 | Activation, bit 7 sign, bits 6:0 magnitude |
| in_wgt | input | 8 | Weight, bit 7 sign, bits 6:0 magnitude |
| rd_req | input | 1 | Request a readout of the current totals |
| res_valid | output | 1 | Result valid for one cycle |
| res_data | output | 25 | Signed two's-complement result (positive minus negative) |

## Verification
The bench drives operands whose weights set only bits 6:4 or only bits 3:0, and weights with all seven bits set. A wrong shift amount or a swapped slice shows up as a wrong sum. Negative zero and zero magnitudes with every sign combination are offered: a design that acted on the sign alone would move a bank it should leave alone. Long runs of full-scale products into each bank expose a counter too narrow for 256 operations as a wrapped result. Readouts that come straight after an operation, after a clear, and back to back catch an off-by-one in result timing and a readout that disturbs the counters.

// File: rtl/ssmac_pkg.sv
package ssmac_pkg;

    typedef enum logic {
        BANK_NEG = 1'b0,
        BANK_POS = 1'b1
    } bank_e;

    localparam int NUM_BANKS = 2;

    // Product sign is positive when both operand signs agree.
    function automatic bank_e pick_bank(input logic act_sign, input logic wgt_sign);
        return (act_sign ~^ wgt_sign) ? BANK_POS : BANK_NEG;
    endfunction

endpackage

// File: rtl/ssmac_route.sv
module ssmac_route
    import ssmac_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LO_W   = 4,
    localparam int MAG_W = DATA_W - 1,
    localparam int HI_W  = MAG_W - LO_W
) (
    input  logic                 fire,
    input  logic [DATA_W-1:0]    act,
    input  logic [DATA_W-1:0]    wgt,
    output logic [NUM_BANKS-1:0] bank_en,
    output logic [MAG_W-1:0]     amag,
    output logic [HI_W-1:0]      whi,
    output logic [LO_W-1:0]      wlo
);
    bank_e sel;
    logic  nonzero;

    always_comb begin
        amag    = act[MAG_W-1:0];
        whi     = wgt[MAG_W-1:LO_W];
        wlo     = wgt[LO_W-1:0];
        sel     = pick_bank(act[DATA_W-1], wgt[DATA_W-1]);
        nonzero = (|act[MAG_W-1:0]) && (|wgt[MAG_W-1:0]);
        bank_en = '0;
        if (fire && nonzero) begin
            bank_en[sel] = 1'b1;
        end
    end
endmodule

// File: rtl/ssmac_subacc.sv
module ssmac_subacc #(
    parameter int MAG_W = 7,
    parameter int SL_W  = 4,
    parameter int ACC_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             en,
    input  logic [MAG_W-1:0] amag,
    input  logic [SL_W-1:0]  slice,
    output logic [ACC_W-1:0] acc
);
    logic [ACC_W-1:0] prod;

    assign prod = ACC_W'(amag) * ACC_W'(slice);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + prod;
        end
    end

    // R6: a clear leaves the counter empty on the next cycle
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc == '0));

    // R8: an accumulation never wraps below the previous value
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (en && !clear) |=> (acc >= $past(acc)));
endmodule

// File: rtl/ssmac_readout.sv
module ssmac_readout #(
    parameter int ACC_W = 19,
    parameter int LO_W  = 4,
    parameter int RES_W = 25,
    localparam int TOT_W = ACC_W + LO_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_req,
    input  logic [ACC_W-1:0] pos_hi,
    input  logic [ACC_W-1:0] pos_lo,
    input  logic [ACC_W-1:0] neg_hi,
    input  logic [ACC_W-1:0] neg_lo,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data
);
    logic [TOT_W-1:0] pos_tot;
    logic [TOT_W-1:0] neg_tot;
    logic [RES_W-1:0] diff;

    always_comb begin
        pos_tot = {1'b0, pos_hi, {LO_W{1'b0}}} + TOT_W'(pos_lo);
        neg_tot = {1'b0, neg_hi, {LO_W{1'b0}}} + TOT_W'(neg_lo);
        diff    = RES_W'(pos_tot) - RES_W'(neg_tot);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= rd_req;
            if (rd_req) begin
                res_data <= diff;
            end
        end
    end

    // R7: every request yields a result on the next cycle
    assert_result_follows_R7: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> res_valid);

    // R7: no result appears without a request
    assert_result_single_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !res_valid);
endmodule

// File: rtl/ssmac_top.sv
module ssmac_top
    import ssmac_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int LO_W    = 4,
    parameter int MAX_OPS = 256,
    localparam int MAG_W  = DATA_W - 1,
    localparam int HI_W   = MAG_W - LO_W,
    localparam int ACC_W  = MAG_W + LO_W + $clog2(MAX_OPS),
    localparam int RES_W  = ACC_W + LO_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_act,
    input  logic [DATA_W-1:0] in_wgt,
    input  logic              rd_req,
    output logic              res_valid,
    output logic [RES_W-1:0]  res_data
);
    logic                 fire;
    logic [NUM_BANKS-1:0] bank_en;
    logic [MAG_W-1:0]     amag;
    logic [HI_W-1:0]      whi;
    logic [LO_W-1:0]      wlo;
    logic [ACC_W-1:0]     acc_hi [NUM_BANKS];
    logic [ACC_W-1:0]     acc_lo [NUM_BANKS];

    assign in_ready = !clear;
    assign fire     = in_valid && in_ready;

    ssmac_route #(.DATA_W(DATA_W), .LO_W(LO_W)) u_route (
        .fire    (fire),
        .act     (in_act),
        .wgt     (in_wgt),
        .bank_en (bank_en),
        .amag    (amag),
        .whi     (whi),
        .wlo     (wlo)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ssmac_subacc #(.MAG_W(MAG_W), .SL_W(HI_W), .ACC_W(ACC_W)) u_hi (
            .clk   (clk),
            .rst   (rst),
            .clear (clear),
            .en    (bank_en[b]),
            .amag  (amag),
            .slice (whi),
            .acc   (acc_hi[b])
        );
        ssmac_subacc #(.MAG_W(MAG_W), .SL_W(LO_W), .ACC_W(ACC_W)) u_lo (
            .clk   (clk),
            .rst   (rst),
            .clear (clear),
            .en    (bank_en[b]),
            .amag  (amag),
            .slice (wlo),
            .acc   (acc_lo[b])
        );
    end

    ssmac_readout #(.ACC_W(ACC_W), .LO_W(LO_W), .RES_W(RES_W)) u_readout (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (rd_req),
        .pos_hi    (acc_hi[BANK_POS]),
        .pos_lo    (acc_lo[BANK_POS]),
        .neg_hi    (acc_hi[BANK_NEG]),
        .neg_lo    (acc_lo[BANK_NEG]),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    // R2: a same-sign operation leaves the negative bank untouched
    assert_same_sign_to_pos_R2: assert property (@(posedge clk) disable iff (rst)
        (fire && (in_act[DATA_W-1] == in_wgt[DATA_W-1])) |=>
            ($stable(acc_hi[BANK_NEG]) && $stable(acc_lo[BANK_NEG])));

    // R3: a mixed-sign operation leaves the positive bank untouched
    assert_mixed_sign_to_neg_R3: assert property (@(posedge clk) disable iff (rst)
        (fire && (in_act[DATA_W-1] != in_wgt[DATA_W-1])) |=>
            ($stable(acc_hi[BANK_POS]) && $stable(acc_lo[BANK_POS])));

    // R5: a zero magnitude changes no counter
    assert_zero_mag_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (fire && ((in_act[MAG_W-1:0] == '0) || (in_wgt[MAG_W-1:0] == '0))) |=>
            ($stable(acc_hi[BANK_POS]) && $stable(acc_lo[BANK_POS]) &&
             $stable(acc_hi[BANK_NEG]) && $stable(acc_lo[BANK_NEG])));

    // R9: no operand is taken while clearing
    assert_ready_low_in_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clear |-> !(|bank_en));
endmodule

// File: tb/test_ssmac_top.sv
module test_ssmac_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clear = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_act = '0;
    logic [7:0]  in_wgt = '0;
    logic        rd_req = 1'b0;
    logic        res_valid;
    logic [24:0] res_data;

    int total = 0;
    int bad   = 0;
    int model = 0;
    bit done  = 1'b0;
    int    exp_q [$];
    string tag_q [$];

    always #2ns clk = ~clk;

    ssmac_top i_ssmac_top (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_act    (in_act),
        .in_wgt    (in_wgt),
        .rd_req    (rd_req),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    function automatic int signed_prod(input logic [7:0] a, input logic [7:0] w);
        int m;
        m = int'(a[6:0]) * int'(w[6:0]);
        return (a[7] == w[7]) ? m : -m;
    endfunction

    task automatic idle();
        @(posedge clk); #1;
        in_valid = 1'b0; rd_req = 1'b0; clear = 1'b0;
    endtask

    task automatic op(input logic [7:0] a, input logic [7:0] w);
        @(posedge clk); #1;
        in_valid = 1'b1; in_act = a; in_wgt = w; rd_req = 1'b0; clear = 1'b0;
        model += signed_prod(a, w);
    endtask

    task automatic rd(input string tag);
        @(posedge clk); #1;
        in_valid = 1'b0; rd_req = 1'b1; clear = 1'b0;
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    task automatic clr();
        @(posedge clk); #1;
        in_valid = 1'b0; rd_req = 1'b0; clear = 1'b1;
        model = 0;
    endtask

    task automatic check_bit(input string tag, input logic act, input logic expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, expv);
        end
    endtask

    // Monitor: pops one expected value per result
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R7 unexpected result actual=%0d expected=none",
                         int'($signed(res_data)));
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (int'($signed(res_data)) != e) begin
                    bad++;
                    $display("FAIL %s actual=%0d expected=%0d", t, int'($signed(res_data)), e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check_bit("R1 res_valid after reset", res_valid, 1'b0);
        rd("R1 empty readout");
        idle();

        op(8'h03, 8'h01);
        op(8'h85, 8'h92);                 // both negative: +90
        rd("R2 same sign adds");
        op(8'h05, 8'h83);                 // mixed: -15
        rd("R3 mixed sign subtracts");
        op(8'h84, 8'h06);                 // mixed other way: -24
        rd("R3 negative activation");

        op(8'h01, 8'h7F);
        op(8'h02, 8'h10);                 // only upper slice
        op(8'h03, 8'h0F);                 // only lower slice
        op(8'h7F, 8'h70);
        rd("R4 slice recombine");

        op(8'h80, 8'h7F);                 // negative zero activation
        op(8'h05, 8'h80);                 // negative zero weight
        op(8'h00, 8'h85);
        op(8'h83, 8'h00);
        rd("R5 zero magnitude ignored");

        rd("R10 repeat readout");
        rd("R7 back to back a");
        rd("R7 back to back b");
        idle();

        clr();
        rd("R6 clear empties");
        op(8'h11, 8'h22);
        @(posedge clk); #1;
        in_valid = 1'b1; clear = 1'b1; in_act = 8'h7F; in_wgt = 8'h7F;
        model = 0;
        @(negedge clk);
        check_bit("R9 ready low in clear", in_ready, 1'b0);
        rd("R9 op during clear dropped");
        idle();

        for (int i = 0; i < 48; i++) begin
            op(8'((i * 37 + 5) & 8'hFF), 8'((i * 91 + 13) & 8'hFF));
            if (i % 8 == 7) rd("R4 mixed pattern");
        end
        idle();

        clr();
        for (int i = 0; i < 256; i++) op(8'h7F, 8'h7F);
        rd("R8 full positive bank");
        clr();
        for (int i = 0; i < 256; i++) op(8'hFF, 8'h7F);
        rd("R8 full negative bank");
        for (int i = 0; i < 256; i++) op(8'h7F, 8'h7F);
        rd("R8 both banks full");
        idle();

        repeat (4) @(posedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R7 missing results actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule